// File: doc/BRIEF.md
# Hashed Page Table Walker (32-bit)

This block turns a 32-bit effective address into a page table entry. It uses the segment register value supplied with the request and a hashed page table in memory. From the segment ID and the page index it forms a hash. It locates the entry group that the hash selects and scans that group's slots one at a time. If the scan finds no match, it repeats the search in a second group, which is selected by the complemented hash. The result goes back to the requester:

- whether the walk hit or missed
- the byte address of the matching entry
- both words of that entry
- the access key
- the access type, passed through unchanged

Permission checking, real-mode bypass and reference/change updates sit downstream and are not part of this block.

Requests and responses use valid/ready handshakes. The block holds one walk at a time and accepts a new request only while it is idle. A response stays presented, unchanged, until the consumer takes it. Memory is reached through a single-word read port. Each request on that port is a valid/ready handshake, and each accepted read returns exactly one data beat on a response-valid strobe. The port has no ready signal on the return side, so the memory may stall requests but must always deliver data.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the response has been accepted.
- R3: The address fields and group addresses are formed as follows:
  - The segment ID is `req_sr[23:0]`.
  - The page index is `req_ea[27:12]`.
  - The primary hash is the segment ID XOR the zero-extended page index (24 bits).
  - A group address is `req_base + ((hash << 6) & req_mask)`.
- R4: Entry layout and the match rule:
  - Slot i of a group lies at group address + 8*i.
  - Each entry's first word is at +0 and its second word at +4.
  - A first word matches when bit 31 is 1, bit 6 equals the pass (0 primary, 1 secondary), bits 30:7 equal the segment ID, and bits 5:0 equal page-index bits 15:10.
  - Slots are scanned from 0 up to 7, and the lowest matching slot wins.
- R5: The secondary group uses the 24-bit complement of the primary hash. It is read only when all eight primary slots miss. A hit in primary slot s costs s+2 memory reads. A hit in secondary slot s costs s+10 reads.
- R6: On a hit the response carries `rsp_hit`=1, `rsp_offset` set to the matching entry's byte address, and both entry words.
- R7: When both groups miss, the response comes after exactly 16 reads, with `rsp_hit`, `rsp_offset`, `rsp_w0` and `rsp_w1` all 0.
- R8: `rsp_key` is `req_sr[29]` when `req_pr` is 1, and `req_sr[30]` when `req_pr` is 0.
- R9: `rsp_acc` equals the `req_acc` value of the request being answered.
- R10: Outputs hold steady under back-pressure:
  - While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and all response fields hold.
  - While `mem_req_valid` is 1 and `mem_req_ready` is 0, `mem_req_valid` and `mem_req_addr` hold.
- R11: At most one memory read is outstanding. No new read is issued until the previous data beat has arrived. Every read address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_ea | input | 32 | Effective address |
| req_sr | input | 32 | Segment register value (ID in 23:0, user key 29, supervisor key 30) |
| req_pr | input | 1 | Problem (user) state flag |
| req_base | input | 32 | Page table base byte address |
| req_mask | input | 32 | Page table offset mask |
| req_acc | input | 2 | Access type, passed through |
| rsp_valid | output | 1 | Walk result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | Matching entry found |
| rsp_offset | output | 32 | Byte address of the matching entry, 0 on miss |
| rsp_w0 | output | 32 | First word of the entry, 0 on miss |
| rsp_w1 | output | 32 | Second word of the entry, 0 on miss |
| rsp_key | output | 1 | Access key selected by privilege |
| rsp_acc | output | 2 | Access type of the answered request |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Word-aligned read address |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 32 | Read data |

## Verification
The assertions assume the memory returns exactly one data beat per accepted read and never returns a beat when no read is pending. The bench memory model issues each beat one cycle after acceptance and stalls requests on a fixed rhythm. The response checks also assume `req_mask` keeps group offsets inside the table, with their low 6 bits clear. The bench meets this by using a 16-group table, which guarantees that the primary and secondary groups never coincide. Decoy entries in every slot differ from the true tag in exactly one field (valid, hash-select, segment ID or abbreviated index), so each condition of the match rule is exercised on its own.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD0,
    S_W0,
    S_RD1,
    S_W1,
    S_DONE
  } walk_state_e;

  localparam int KEY_USER_BIT = 29;
  localparam int KEY_SUP_BIT  = 30;
  localparam int VALID_BIT    = 31;
endpackage

// File: rtl/ptw_hash.sv
module ptw_hash #(
  parameter int VSID_W    = 24,
  parameter int PIDX_W    = 16,
  parameter int API_W     = 6,
  parameter int GRP_SHIFT = 6
) (
  input  logic [PIDX_W-1:0] pidx,
  input  logic [VSID_W-1:0] vsid,
  input  logic [31:0]       base,
  input  logic [31:0]       mask,
  output logic [API_W-1:0]  api,
  output logic [31:0]       grp_pri,
  output logic [31:0]       grp_sec
);
  logic [VSID_W-1:0] hash_p;
  logic [VSID_W-1:0] hash_s;

  always_comb begin
    hash_p  = vsid ^ VSID_W'(pidx);
    hash_s  = ~hash_p;
    api     = pidx[PIDX_W-1 -: API_W];
    grp_pri = base + ((32'(hash_p) << GRP_SHIFT) & mask);
    grp_sec = base + ((32'(hash_s) << GRP_SHIFT) & mask);
  end
endmodule

// File: rtl/ptw_match.sv
module ptw_match #(
  parameter int VSID_W = 24,
  parameter int API_W  = 6
) (
  input  logic [31:0]       word,
  input  logic [VSID_W-1:0] vsid,
  input  logic [API_W-1:0]  api,
  input  logic              pass,
  output logic              match
);
  import ptw_pkg::*;
  localparam int H_POS    = API_W;
  localparam int VSID_LSB = API_W + 1;

  always_comb begin
    match = word[VALID_BIT]
         && (word[H_POS] == pass)
         && (word[VSID_LSB +: VSID_W] == vsid)
         && (word[API_W-1:0] == api);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int SLOTS     = 8,
  parameter int PAGE_BITS = 12,
  parameter int VSID_W    = 24,
  parameter int API_W     = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_ea,
  input  logic [31:0] req_sr,
  input  logic        req_pr,
  input  logic [31:0] req_base,
  input  logic [31:0] req_mask,
  input  logic [1:0]  req_acc,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_hit,
  output logic [31:0] rsp_offset,
  output logic [31:0] rsp_w0,
  output logic [31:0] rsp_w1,
  output logic        rsp_key,
  output logic [1:0]  rsp_acc,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  import ptw_pkg::*;

  localparam int SEG_BITS    = 28;
  localparam int PIDX_W      = SEG_BITS - PAGE_BITS;
  localparam int ENTRY_BYTES = 8;
  localparam int W1_OFF      = 4;
  localparam int SLOT_W      = $clog2(SLOTS);
  localparam int ENT_SHIFT   = $clog2(ENTRY_BYTES);
  localparam int GRP_SHIFT   = $clog2(SLOTS * ENTRY_BYTES);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  walk_state_e       state_q;
  logic              pass_q;
  logic [SLOT_W-1:0] slot_q;
  logic [31:0]       grp_pri_q, grp_sec_q;
  logic [VSID_W-1:0] vsid_q;
  logic [API_W-1:0]  api_q;
  logic              key_q;
  logic [1:0]        acc_q;
  logic              hit_q;
  logic [31:0]       off_q, w0_q, w1_q;

  logic [API_W-1:0]  api_c;
  logic [31:0]       grp_pri_c, grp_sec_c;
  logic [31:0]       ent_addr;
  logic              slot_match;
  logic              key_c;
  logic              unused_bits;

  assign unused_bits = ^{req_ea[31:SEG_BITS], req_ea[PAGE_BITS-1:0],
                         req_sr[31], req_sr[28:VSID_W]};

  ptw_hash #(
    .VSID_W(VSID_W), .PIDX_W(PIDX_W), .API_W(API_W), .GRP_SHIFT(GRP_SHIFT)
  ) u_hash (
    .pidx    (req_ea[SEG_BITS-1:PAGE_BITS]),
    .vsid    (req_sr[VSID_W-1:0]),
    .base    (req_base),
    .mask    (req_mask),
    .api     (api_c),
    .grp_pri (grp_pri_c),
    .grp_sec (grp_sec_c)
  );

  ptw_match #(.VSID_W(VSID_W), .API_W(API_W)) u_match (
    .word  (mem_rsp_data),
    .vsid  (vsid_q),
    .api   (api_q),
    .pass  (pass_q),
    .match (slot_match)
  );

  assign key_c    = req_pr ? req_sr[KEY_USER_BIT] : req_sr[KEY_SUP_BIT];
  assign ent_addr = (pass_q ? grp_sec_q : grp_pri_q) + (32'(slot_q) << ENT_SHIFT);

  assign req_ready     = (state_q == S_IDLE);
  assign rsp_valid     = (state_q == S_DONE);
  assign mem_req_valid = (state_q == S_RD0) || (state_q == S_RD1);
  assign mem_req_addr  = (state_q == S_RD1) ? ent_addr + 32'(W1_OFF) : ent_addr;
  assign rsp_hit       = hit_q;
  assign rsp_offset    = off_q;
  assign rsp_w0        = w0_q;
  assign rsp_w1        = w1_q;
  assign rsp_key       = key_q;
  assign rsp_acc       = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      pass_q    <= 1'b0;
      slot_q    <= '0;
      grp_pri_q <= '0;
      grp_sec_q <= '0;
      vsid_q    <= '0;
      api_q     <= '0;
      key_q     <= 1'b0;
      acc_q     <= '0;
      hit_q     <= 1'b0;
      off_q     <= '0;
      w0_q      <= '0;
      w1_q      <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          grp_pri_q <= grp_pri_c;
          grp_sec_q <= grp_sec_c;
          vsid_q    <= req_sr[VSID_W-1:0];
          api_q     <= api_c;
          key_q     <= key_c;
          acc_q     <= req_acc;
          pass_q    <= 1'b0;
          slot_q    <= '0;
          hit_q     <= 1'b0;
          off_q     <= '0;
          w0_q      <= '0;
          w1_q      <= '0;
          state_q   <= S_RD0;
        end
        S_RD0: if (mem_req_ready) state_q <= S_W0;
        S_W0: if (mem_rsp_valid) begin
          if (slot_match) begin
            w0_q    <= mem_rsp_data;
            state_q <= S_RD1;
          end else if (slot_q == LAST_SLOT) begin
            slot_q <= '0;
            if (!pass_q) begin
              pass_q  <= 1'b1;
              state_q <= S_RD0;
            end else begin
              state_q <= S_DONE;
            end
          end else begin
            slot_q  <= slot_q + SLOT_W'(1);
            state_q <= S_RD0;
          end
        end
        S_RD1: if (mem_req_ready) state_q <= S_W1;
        S_W1: if (mem_rsp_valid) begin
          w1_q    <= mem_rsp_data;
          off_q   <= ent_addr;
          hit_q   <= 1'b1;
          state_q <= S_DONE;
        end
        S_DONE: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_hit,
  input logic [31:0] rsp_offset,
  input logic [31:0] rsp_w0,
  input logic [31:0] rsp_w1,
  input logic        rsp_key,
  input logic [1:0]  rsp_acc,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_valid
);
  logic busy_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (req_valid && req_ready) busy_q <= 1'b1;
      else if (rsp_valid && rsp_ready) busy_q <= 1'b0;
      if (mem_req_valid && mem_req_ready) pend_q <= 1'b1;
      else if (mem_rsp_valid) pend_q <= 1'b0;
    end
  end

  a_r2_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !req_ready);

  a_r4_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_offset[2:0] == 3'b000));

  a_r6_hit_entry_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> rsp_w0[31]);

  a_r7_miss_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_offset == 32'd0 && rsp_w0 == 32'd0 && rsp_w1 == 32'd0));

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_offset)
      && $stable(rsp_w0) && $stable(rsp_w1) && $stable(rsp_key) && $stable(rsp_acc)));

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !mem_req_valid);

  a_r11_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] MASK = 32'h0000_03C0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_ea = '0, req_sr = '0, req_base = BASE, req_mask = MASK;
  logic        req_pr = 1'b0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid, rsp_hit, rsp_key;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_offset, rsp_w0, rsp_w1;
  logic [1:0]  rsp_acc;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  logic [31:0] mem [0:255];
  int unsigned cyc = 0;
  int unsigned rd_cnt = 0;
  int unsigned overlap_cnt = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea), .req_sr(req_sr),
    .req_pr(req_pr), .req_base(req_base), .req_mask(req_mask), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_offset(rsp_offset), .rsp_w0(rsp_w0), .rsp_w1(rsp_w1), .rsp_key(rsp_key),
    .rsp_acc(rsp_acc), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [7:0] widx(logic [31:0] a);
    logic [31:0] d;
    d = (a - BASE) >> 2;
    return d[7:0];
  endfunction

  // memory model: stalls on a fixed rhythm, returns data one cycle after acceptance
  always_ff @(posedge clk) begin
    cyc           <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem[widx(mem_req_addr)];
    if (mem_req_valid && mem_req_ready) begin
      rd_cnt <= rd_cnt + 1;
      if (mem_rsp_valid) overlap_cnt <= overlap_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] decoy(logic [31:0] tag, int i);
    case (i % 4)
      0: return tag & ~32'h8000_0000;
      1: return tag ^ 32'h0000_0040;
      2: return tag ^ 32'h0000_0080;
      default: return tag ^ 32'h0000_0001;
    endcase
  endfunction

  // mode 0: primary hit at slot s, mode 1: secondary hit at slot s, mode 2: miss
  task automatic run_case(input int mode, input int s, input int v);
    int t;
    logic [31:0] ea, sr, g0, g1, tag0, tag1, d1, exp_off, exp_w0, exp_w1;
    logic [23:0] vsid, h;
    logic [15:0] pg;
    logic pr, exp_key, exp_hit;
    int unsigned rd0, exp_rd;
    logic [31:0] s_off, s_w0, s_w1;
    logic s_hit;
    int wait_n;
    t    = mode * 64 + s * 8 + v;
    ea   = (32'(t) * 32'h0913_7000) ^ 32'h5A5A_5ABC;
    sr   = ((32'(t) * 32'h0019_3D45 + 32'h00A5_0F11) & 32'h00FF_FFFF)
         | (32'(t & 1) << 29) | (32'((t >> 1) & 1) << 30);
    pr   = ((t >> 2) & 1) != ((t >> 3) & 1);
    vsid = sr[23:0];
    pg   = ea[27:12];
    h    = vsid ^ {8'h00, pg};
    g0   = BASE + ({2'b00, h, 6'b0} & MASK);
    g1   = BASE + ({2'b00, ~h, 6'b0} & MASK);
    tag0 = {1'b1, vsid, 1'b0, pg[15:10]};
    tag1 = {1'b1, vsid, 1'b1, pg[15:10]};
    d1   = 32'hC000_0000 | 32'(t);
    exp_key = pr ? sr[29] : sr[30];
    for (int i = 0; i < 256; i++) mem[i] = '0;
    exp_hit = 1'b0; exp_off = '0; exp_w0 = '0; exp_w1 = '0; exp_rd = 16;
    if (mode == 0) begin
      for (int i = 0; i < 8; i++) begin
        mem[widx(g0 + 32'(8*i))]     = (i < s) ? decoy(tag0, i + v) : tag0;
        mem[widx(g0 + 32'(8*i) + 4)] = d1 + 32'(i << 8);
      end
      mem[widx(g1)] = tag1;
      exp_hit = 1'b1; exp_off = g0 + 32'(8*s); exp_w0 = tag0;
      exp_w1 = d1 + 32'(s << 8); exp_rd = 32'(s + 2);
    end else begin
      for (int i = 0; i < 8; i++) begin
        mem[widx(g0 + 32'(8*i))] = decoy(tag0, i + v);
        mem[widx(g1 + 32'(8*i))] = (mode == 1 && i >= s) ? tag1 : decoy(tag1, i + v);
        mem[widx(g1 + 32'(8*i) + 4)] = d1 + 32'(i << 8);
      end
      if (mode == 1) begin
        exp_hit = 1'b1; exp_off = g1 + 32'(8*s); exp_w0 = tag1;
        exp_w1 = d1 + 32'(s << 8); exp_rd = 32'(s + 10);
      end
    end
    @(negedge clk);
    chk("R2 idle ready", {31'd0, req_ready}, 32'd1);
    rd0 = rd_cnt;
    req_ea = ea; req_sr = sr; req_pr = pr; req_acc = 2'(t); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 busy after accept", {31'd0, req_ready}, 32'd0);
    wait_n = 0;
    while (!rsp_valid && wait_n < 400) begin
      @(negedge clk);
      wait_n++;
    end
    s_hit = rsp_hit; s_off = rsp_offset; s_w0 = rsp_w0; s_w1 = rsp_w1;
    chk("R6/R7 hit flag", {31'd0, rsp_hit}, {31'd0, exp_hit});
    chk("R3/R4/R6 offset", rsp_offset, exp_off);
    chk("R4/R6 word0", rsp_w0, exp_w0);
    chk("R6 word1", rsp_w1, exp_w1);
    chk("R8 key", {31'd0, rsp_key}, {31'd0, exp_key});
    chk("R9 access type", {30'd0, rsp_acc}, 32'(t & 3));
    chk("R5/R7 read count", rd_cnt - rd0, exp_rd);
    repeat (2) @(negedge clk);
    chk("R10 held valid", {31'd0, rsp_valid}, 32'd1);
    chk("R10 held fields", {31'd0, rsp_hit} ^ s_off ^ rsp_w0 ^ rsp_w1,
        {31'd0, s_hit} ^ rsp_offset ^ s_w0 ^ s_w1);
    chk("R10 held offset", rsp_offset, s_off);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R2 released", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 8; s++)
        for (int v = 0; v < 4; v++)
          run_case(m, s, v);
    chk("R11 overlapping reads", overlap_cnt, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule